// File: doc/BRIEF.md
# Breakpoint Trigger Pair Resolver

This block turns raw address comparisons into trap decisions for ten hardware breakpoint triggers. Every trigger watches one address stream: instruction fetch, load or store. Each trigger compares its stream against a stored value using a selectable relation. The triggers are grouped into five fixed pairs, and trigger 2p is paired with trigger 2p+1. A pair can be chained so that it fires only when both of its members see a match in the same cycle.

The block reports in the current cycle whether any trigger fires. It also reports whether the trap belongs before the instruction that matched or before the one that follows it, and whether a firing trigger asked for entry into debug mode. A register records which triggers have fired, and a small state machine records the kind of trap that is outstanding. Both stay set until the `clear` input is pulsed.

Configuration is written one trigger at a time through a valid-qualified port. The fetch side and the memory side each have their own slot numbering.

The pending state machine has three states:
- `PS_IDLE`: nothing is pending.
- `PS_HELD_NEXT`: the trap is pending and belongs before the next instruction.
- `PS_HELD_NOW`: the trap is pending and belongs before the matching instruction.

It has these transitions:
- `clear` moves any state to `PS_IDLE`.
- In `PS_IDLE`, a fire with `fire_after`=1 moves to `PS_HELD_NEXT`.
- In `PS_IDLE` or `PS_HELD_NEXT`, a fire with `fire_after`=0 moves to `PS_HELD_NOW`. This is the upgrade from a next-instruction trap to a current-instruction trap.
- `PS_HELD_NOW` holds until `clear`.

Top module: `brk_chain_resolver`

## Requirements
- R1: A write with `cfg_mem`=0 uses `cfg_idx[1:0]`. Slots 0, 1, 2 and 3 select triggers 0, 1, 6 and 8. A write with `cfg_mem`=1 uses slots 0 to 5, which select triggers 2, 3, 4, 5, 7 and 9. Memory slots 6 and 7 change nothing. A write takes effect from the next cycle.
- R2: Each trigger compares only its own stream. Triggers 0, 1, 6 and 8 watch fetch, triggers 2, 3 and 7 watch store, and triggers 4, 5 and 9 watch load. The stream's valid bit must be high. Match type 0 means address equals the value. Match type 1 means address is greater than or equal to the value, unsigned. Match type 2 means address is less than the value. Match type 3 never matches.
- R3: A trigger whose bit in `trig_en` is 0 never hits. A trigger whose select bit is 1 never hits, because data-value comparison is not supported.
- R4: A pair is chained when either member's chain bit is set. A chained pair fires both members only when both of them hit.
- R5: A chained pair whose two members have different timing bits never fires.
- R6: Pair 1 (triggers 2 and 3, both store) ignores its chain bits and behaves as unchained.
- R7: In an unchained pair, each member fires on its own hit. `fire` is high when any trigger fires. `fire_after` is high only when every firing trigger has timing bit 1; timing 0 (current instruction) takes priority.
- R8: `fire_debug` is high when any firing trigger has its action bit set.
- R9: `pend_hits` holds the OR of fired triggers since the last clear. When `clear` is high it is zero after the edge, even if triggers fire in that cycle.
- R10: `pend_valid` and `pend_after` follow the pending state machine. `pend_valid` is high outside `PS_IDLE`. `pend_after` is high only in `PS_HELD_NEXT`.
- R11: After reset, all outputs are zero and every trigger's stored configuration is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_mem | input | 1 | 0 = fetch-side slot, 1 = memory-side slot |
| cfg_idx | input | 3 | Slot number |
| cfg_mtype | input | 2 | Match type |
| cfg_sel | input | 1 | Select bit (1 = data compare, never hits) |
| cfg_timing | input | 1 | 0 = trap at this instruction, 1 = at the next |
| cfg_action | input | 1 | Debug-mode request |
| cfg_chain | input | 1 | Chain request |
| cfg_value | input | VAL_W | Compare value |
| trig_en | input | 10 | Per-trigger enable |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_addr | input | VAL_W | Fetch address |
| load_valid | input | 1 | Load address valid |
| load_addr | input | VAL_W | Load address |
| store_valid | input | 1 | Store address valid |
| store_addr | input | VAL_W | Store address |
| clear | input | 1 | Clears pending flags and state |
| fire | output | 1 | Some trigger fires this cycle |
| fire_after | output | 1 | The trap belongs before the next instruction |
| fire_debug | output | 1 | A firing trigger requests debug mode |
| pend_hits | output | 10 | Sticky per-trigger fired flags |
| pend_valid | output | 1 | A trap is pending |
| pend_after | output | 1 | The pending trap belongs before the next instruction |

## Verification
The bench builds the block with `VAL_W`=16. This keeps the compare values short and makes the greater-or-equal and less-than boundaries easy to reach one address apart. The pair structure, the slot mapping and the store-pair rule do not depend on `VAL_W`, so every pair type is still covered. The tests cover:
- chaining in the fetch pair, the store pair and a mixed fetch/store pair;
- a chained pair with mismatched timing bits;
- timing priority in an unchained pair;
- the upgrade from `PS_HELD_NEXT` to `PS_HELD_NOW`;
- a clear that arrives in the same cycle as a fire.

// File: rtl/brk_res_pkg.sv
package brk_res_pkg;

    localparam int NTRIG = 10;
    localparam int NPAIR = NTRIG / 2;

    typedef enum logic [1:0] {
        CLS_FETCH = 2'd0,
        CLS_LOAD  = 2'd1,
        CLS_STORE = 2'd2
    } trig_cls_e;

    typedef enum logic [1:0] {
        MT_EQ   = 2'd0,
        MT_GE   = 2'd1,
        MT_LT   = 2'd2,
        MT_NONE = 2'd3
    } mtype_e;

    typedef struct packed {
        mtype_e mtype;
        logic   sel;
        logic   timing;
        logic   action;
        logic   chain;
    } trig_ctl_t;

    typedef enum logic [1:0] {
        PS_IDLE      = 2'd0,
        PS_HELD_NOW  = 2'd1,
        PS_HELD_NEXT = 2'd2
    } pend_state_e;

    // Stream watched by each trigger; the pairing fixes this.
    function automatic trig_cls_e cls_of(input int t);
        case (t)
            0, 1, 6, 8: return CLS_FETCH;
            2, 3, 7:    return CLS_STORE;
            default:    return CLS_LOAD;
        endcase
    endfunction

    // Fetch-side slot to trigger number.
    function automatic int fetch_slot(input logic [1:0] k);
        case (k)
            2'd0:    return 0;
            2'd1:    return 1;
            2'd2:    return 6;
            default: return 8;
        endcase
    endfunction

    // Memory-side slot to trigger number; 15 means no trigger.
    function automatic int mem_slot(input logic [2:0] k);
        case (k)
            3'd0:    return 2;
            3'd1:    return 3;
            3'd2:    return 4;
            3'd3:    return 5;
            3'd4:    return 7;
            3'd5:    return 9;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/brk_cfg_bank.sv
module brk_cfg_bank
    import brk_res_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_valid,
    input  logic                        cfg_mem,
    input  logic [2:0]                  cfg_idx,
    input  trig_ctl_t                   cfg_ctl,
    input  logic [VAL_W-1:0]            cfg_value,
    output trig_ctl_t [NTRIG-1:0]       ctl_q,
    output logic [NTRIG-1:0][VAL_W-1:0] val_q
);

    logic [NTRIG-1:0] wr_sel;

    for (genvar t = 0; t < NTRIG; t++) begin : g_slot
        always_comb begin
            if (cfg_mem) wr_sel[t] = cfg_valid && (mem_slot(cfg_idx) == t);
            else         wr_sel[t] = cfg_valid && (fetch_slot(cfg_idx[1:0]) == t);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[t] <= '0;
                val_q[t] <= '0;
            end else if (wr_sel[t]) begin
                ctl_q[t] <= cfg_ctl;
                val_q[t] <= cfg_value;
            end
        end
    end

    // R1
    unused_slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_mem && cfg_idx[2:1] == 2'b11)
        |=> (ctl_q == $past(ctl_q) && val_q == $past(val_q)));

endmodule

// File: rtl/brk_addr_match.sv
module brk_addr_match
    import brk_res_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic             en,
    input  mtype_e           mtype,
    input  logic             sel,
    input  logic [VAL_W-1:0] cmp,
    input  logic             addr_vld,
    input  logic [VAL_W-1:0] addr,
    output logic             hit
);

    logic rel;

    always_comb begin
        unique case (mtype)
            MT_EQ:   rel = (addr == cmp);
            MT_GE:   rel = (addr >= cmp);
            MT_LT:   rel = (addr <  cmp);
            default: rel = 1'b0;
        endcase
        hit = en && addr_vld && !sel && rel;
    end

endmodule

// File: rtl/brk_pair_resolve.sv
module brk_pair_resolve #(
    parameter bit CHAIN_OK = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_a,
    input  logic hit_b,
    input  logic chain_req,
    input  logic tim_a,
    input  logic tim_b,
    output logic fire_a,
    output logic fire_b
);

    logic chained;
    logic both;

    assign chained = CHAIN_OK && chain_req;
    assign both    = hit_a && hit_b && (tim_a == tim_b);

    always_comb begin
        if (chained) begin
            fire_a = both;
            fire_b = both;
        end else begin
            fire_a = hit_a;
            fire_b = hit_b;
        end
    end

    // R5
    mismatch_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chained && tim_a != tim_b) |-> (!fire_a && !fire_b));

    // R4
    chain_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chained && (fire_a || fire_b)) |-> (hit_a && hit_b));

endmodule

// File: rtl/brk_chain_resolver.sv
module brk_chain_resolver
    import brk_res_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic             cfg_mem,
    input  logic [2:0]       cfg_idx,
    input  logic [1:0]       cfg_mtype,
    input  logic             cfg_sel,
    input  logic             cfg_timing,
    input  logic             cfg_action,
    input  logic             cfg_chain,
    input  logic [VAL_W-1:0] cfg_value,
    input  logic [9:0]       trig_en,
    input  logic             fetch_valid,
    input  logic [VAL_W-1:0] fetch_addr,
    input  logic             load_valid,
    input  logic [VAL_W-1:0] load_addr,
    input  logic             store_valid,
    input  logic [VAL_W-1:0] store_addr,
    input  logic             clear,
    output logic             fire,
    output logic             fire_after,
    output logic             fire_debug,
    output logic [9:0]       pend_hits,
    output logic             pend_valid,
    output logic             pend_after
);

    trig_ctl_t                   cfg_ctl;
    trig_ctl_t [NTRIG-1:0]       ctl_q;
    logic [NTRIG-1:0][VAL_W-1:0] val_q;
    logic [NTRIG-1:0]            hit, fired, tim_v, act_v;
    pend_state_e                 state_q, state_d;

    assign cfg_ctl = '{mtype:  mtype_e'(cfg_mtype), sel: cfg_sel, timing: cfg_timing,
                       action: cfg_action, chain: cfg_chain};

    brk_cfg_bank #(.VAL_W(VAL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_mem   (cfg_mem),
        .cfg_idx   (cfg_idx),
        .cfg_ctl   (cfg_ctl),
        .cfg_value (cfg_value),
        .ctl_q     (ctl_q),
        .val_q     (val_q)
    );

    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        logic             vld;
        logic [VAL_W-1:0] adr;
        if (cls_of(t) == CLS_FETCH) begin : g_fetch
            assign vld = fetch_valid;
            assign adr = fetch_addr;
        end else if (cls_of(t) == CLS_LOAD) begin : g_load
            assign vld = load_valid;
            assign adr = load_addr;
        end else begin : g_store
            assign vld = store_valid;
            assign adr = store_addr;
        end
        assign tim_v[t] = ctl_q[t].timing;
        assign act_v[t] = ctl_q[t].action;

        brk_addr_match #(.VAL_W(VAL_W)) u_match (
            .en       (trig_en[t]),
            .mtype    (ctl_q[t].mtype),
            .sel      (ctl_q[t].sel),
            .cmp      (val_q[t]),
            .addr_vld (vld),
            .addr     (adr),
            .hit      (hit[t])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam bit CHAIN_OK =
            !(cls_of(2*p) == CLS_STORE && cls_of(2*p+1) == CLS_STORE);
        brk_pair_resolve #(.CHAIN_OK(CHAIN_OK)) u_pair (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_a     (hit[2*p]),
            .hit_b     (hit[2*p+1]),
            .chain_req (ctl_q[2*p].chain | ctl_q[2*p+1].chain),
            .tim_a     (tim_v[2*p]),
            .tim_b     (tim_v[2*p+1]),
            .fire_a    (fired[2*p]),
            .fire_b    (fired[2*p+1])
        );
    end

    assign fire       = |fired;
    assign fire_after = fire && ((fired & ~tim_v) == '0);
    assign fire_debug = |(fired & act_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_hits <= '0;
        else if (clear) pend_hits <= '0;
        else            pend_hits <= pend_hits | fired;
    end

    // Pending-trap state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = PS_IDLE;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    if (fire) state_d = fire_after ? PS_HELD_NEXT : PS_HELD_NOW;
                end
                PS_HELD_NEXT: begin
                    if (fire && !fire_after) state_d = PS_HELD_NOW;
                end
                PS_HELD_NOW: state_d = PS_HELD_NOW;
                default:     state_d = PS_IDLE;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        unique case (state_q)
            PS_HELD_NOW: begin
                pend_valid = 1'b1;
                pend_after = 1'b0;
            end
            PS_HELD_NEXT: begin
                pend_valid = 1'b1;
                pend_after = 1'b1;
            end
            default: begin
                pend_valid = 1'b0;
                pend_after = 1'b0;
            end
        endcase
    end

    // R7
    after_implies_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_after |-> fire);

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pend_hits == '0 && !pend_valid));

    // R9
    sticky_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((pend_hits & $past(pend_hits)) == $past(pend_hits)));

    // R10
    now_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !fire_after && !clear) |=> (pend_valid && !pend_after));

endmodule

// File: tb/brk_chain_resolver_test.sv
module brk_chain_resolver_test;

    localparam int VW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 0, cfg_mem = 0, cfg_sel = 0, cfg_timing = 0;
    logic          cfg_action = 0, cfg_chain = 0;
    logic [2:0]    cfg_idx = '0;
    logic [1:0]    cfg_mtype = '0;
    logic [VW-1:0] cfg_value = '0;
    logic [9:0]    trig_en = '0;
    logic          fetch_valid = 0, load_valid = 0, store_valid = 0, clear = 0;
    logic [VW-1:0] fetch_addr = '0, load_addr = '0, store_addr = '0;
    logic          fire, fire_after, fire_debug, pend_valid, pend_after;
    logic [9:0]    pend_hits;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    brk_chain_resolver #(.VAL_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_mem(cfg_mem),
        .cfg_idx(cfg_idx), .cfg_mtype(cfg_mtype), .cfg_sel(cfg_sel),
        .cfg_timing(cfg_timing), .cfg_action(cfg_action), .cfg_chain(cfg_chain),
        .cfg_value(cfg_value), .trig_en(trig_en), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .load_valid(load_valid), .load_addr(load_addr),
        .store_valid(store_valid), .store_addr(store_addr), .clear(clear),
        .fire(fire), .fire_after(fire_after), .fire_debug(fire_debug),
        .pend_hits(pend_hits), .pend_valid(pend_valid), .pend_after(pend_after)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; trig_en = '0; clear = 0;
        fetch_valid = 0; load_valid = 0; store_valid = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wcfg(input logic mem, input logic [2:0] idx, input logic [1:0] mt,
                        input logic sel, input logic tim, input logic act,
                        input logic ch, input logic [VW-1:0] val);
        @(negedge clk);
        cfg_valid = 1; cfg_mem = mem; cfg_idx = idx; cfg_mtype = mt; cfg_sel = sel;
        cfg_timing = tim; cfg_action = act; cfg_chain = ch; cfg_value = val;
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic drive(input logic fv, input logic [VW-1:0] fa, input logic lv,
                         input logic [VW-1:0] la, input logic sv, input logic [VW-1:0] sa);
        @(negedge clk);
        fetch_valid = fv; fetch_addr = fa;
        load_valid  = lv; load_addr  = la;
        store_valid = sv; store_addr = sa;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R11 fire", fire, 0);
        chk("R11 pend_hits", pend_hits, 0);
        chk("R11 pend_valid", pend_valid, 0);
        trig_en = 10'h3FF;
        drive(1, 16'h0001, 1, 16'h0001, 1, 16'h0001);
        chk("R11 zero cfg no match at 1", fire, 0);
    endtask

    task automatic t_mapping();
        do_reset();
        wcfg(0, 3'd3, 2'd0, 0, 0, 0, 0, 16'h0888);
        wcfg(1, 3'd5, 2'd0, 0, 0, 0, 0, 16'h0999);
        wcfg(1, 3'd6, 2'd0, 0, 0, 0, 0, 16'h0777);
        trig_en = 10'h100;
        drive(1, 16'h0888, 0, 0, 0, 0);
        chk("R1 fetch slot3 -> trig8", fire, 1);
        trig_en = 10'h200;
        drive(0, 0, 1, 16'h0999, 0, 0);
        chk("R1 mem slot5 -> trig9", fire, 1);
        trig_en = 10'h3FF;
        drive(1, 16'h0777, 1, 16'h0777, 1, 16'h0777);
        chk("R1 mem slot6 ignored", fire, 0);
    endtask

    task automatic t_mtypes();
        do_reset();
        trig_en = 10'h002;
        wcfg(0, 3'd1, 2'd1, 0, 0, 0, 0, 16'h0200);
        drive(1, 16'h0200, 0, 0, 0, 0); chk("R2 ge at bound", fire, 1);
        drive(1, 16'h01FF, 0, 0, 0, 0); chk("R2 ge below", fire, 0);
        wcfg(0, 3'd1, 2'd2, 0, 0, 0, 0, 16'h0200);
        drive(1, 16'h01FF, 0, 0, 0, 0); chk("R2 lt below", fire, 1);
        drive(1, 16'h0200, 0, 0, 0, 0); chk("R2 lt at bound", fire, 0);
        wcfg(0, 3'd1, 2'd3, 0, 0, 0, 0, 16'h0200);
        drive(1, 16'h0200, 0, 0, 0, 0); chk("R2 reserved type", fire, 0);
        wcfg(0, 3'd1, 2'd0, 0, 0, 0, 0, 16'h0200);
        drive(0, 16'h0200, 0, 0, 0, 0); chk("R2 fetch invalid", fire, 0);
        drive(1, 16'h0200, 0, 0, 0, 0); chk("R2 eq", fire, 1);
        do_reset();
        trig_en = 10'h010;
        wcfg(1, 3'd2, 2'd0, 0, 0, 0, 0, 16'h0444);
        drive(0, 0, 1, 16'h0444, 0, 0); chk("R2 load trig4", fire, 1);
        drive(1, 16'h0444, 0, 0, 1, 16'h0444); chk("R2 load trig ignores store/fetch", fire, 0);
    endtask

    task automatic t_gates();
        do_reset();
        wcfg(0, 3'd0, 2'd0, 0, 0, 0, 0, 16'h0100);
        trig_en = 10'h000;
        drive(1, 16'h0100, 0, 0, 0, 0); chk("R3 disabled", fire, 0);
        trig_en = 10'h001;
        drive(1, 16'h0100, 0, 0, 0, 0); chk("R3 enabled", fire, 1);
        wcfg(0, 3'd0, 2'd0, 1, 0, 0, 0, 16'h0100);
        drive(1, 16'h0100, 0, 0, 0, 0); chk("R3 select bit", fire, 0);
    endtask

    task automatic t_chain();
        do_reset();
        trig_en = 10'h003;
        wcfg(0, 3'd0, 2'd0, 0, 0, 0, 1, 16'h0100);
        wcfg(0, 3'd1, 2'd1, 0, 0, 0, 0, 16'h0080);
        drive(1, 16'h0100, 0, 0, 0, 0); chk("R4 chained both hit", fire, 1);
        wcfg(0, 3'd1, 2'd2, 0, 0, 0, 0, 16'h0080);
        drive(1, 16'h0100, 0, 0, 0, 0); chk("R4 chained one hit", fire, 0);
        wcfg(0, 3'd1, 2'd1, 0, 1, 0, 0, 16'h0080);
        drive(1, 16'h0100, 0, 0, 0, 0); chk("R5 timing mismatch", fire, 0);
        do_reset();
        trig_en = 10'h0C0;
        wcfg(0, 3'd2, 2'd0, 0, 1, 0, 1, 16'h0500);
        wcfg(1, 3'd4, 2'd0, 0, 1, 0, 0, 16'h0600);
        drive(1, 16'h0500, 0, 0, 1, 16'h0600); chk("R4 mixed pair both", fire, 1);
        chk("R4 mixed pair timing", fire_after, 1);
        drive(1, 16'h0500, 0, 0, 0, 16'h0600); chk("R4 mixed pair fetch only", fire, 0);
    endtask

    task automatic t_store_pair();
        do_reset();
        trig_en = 10'h00C;
        wcfg(1, 3'd0, 2'd0, 0, 0, 0, 1, 16'h0300);
        wcfg(1, 3'd1, 2'd0, 0, 0, 0, 1, 16'h0400);
        drive(0, 0, 0, 0, 1, 16'h0300); chk("R6 store pair unchained", fire, 1);
    endtask

    task automatic t_priority();
        do_reset();
        trig_en = 10'h003;
        wcfg(0, 3'd0, 2'd0, 0, 1, 1, 0, 16'h0100);
        wcfg(0, 3'd1, 2'd1, 0, 0, 0, 0, 16'h0080);
        drive(1, 16'h0100, 0, 0, 0, 0);
        chk("R7 both fire", fire, 1);
        chk("R7 current wins", fire_after, 0);
        chk("R8 action set", fire_debug, 1);
        trig_en = 10'h001;
        drive(1, 16'h0100, 0, 0, 0, 0);
        chk("R7 next-only", fire_after, 1);
        trig_en = 10'h002;
        drive(1, 16'h0100, 0, 0, 0, 0);
        chk("R8 action clear", fire_debug, 0);
    endtask

    task automatic t_pending();
        do_reset();
        trig_en = 10'h001;
        wcfg(0, 3'd0, 2'd0, 0, 1, 0, 0, 16'h0100);
        wcfg(0, 3'd1, 2'd0, 0, 0, 0, 0, 16'h0100);
        drive(1, 16'h0100, 0, 0, 0, 0);
        @(posedge clk); #1;
        chk("R9 pend one", pend_hits, 10'h001);
        chk("R10 held next valid", pend_valid, 1);
        chk("R10 held next after", pend_after, 1);
        trig_en = 10'h003;
        @(posedge clk); #1;
        chk("R9 pend two", pend_hits, 10'h003);
        chk("R10 upgrade", pend_after, 0);
        chk("R10 still valid", pend_valid, 1);
        drive(0, 0, 0, 0, 0, 0);
        clear = 1;
        @(posedge clk); #1;
        chk("R9 cleared", pend_hits, 0);
        chk("R10 idle", pend_valid, 0);
        drive(1, 16'h0100, 0, 0, 0, 0);
        @(posedge clk); #1;
        chk("R9 clear beats fire", pend_hits, 0);
        chk("R10 clear beats fire", pend_valid, 0);
        clear = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mapping();
        t_mtypes();
        t_gates();
        t_chain();
        t_store_pair();
        t_priority();
        t_pending();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule